// File: doc/BRIEF.md
# Front-End Trigger Sequencer with Deadtime

This block produces the trigger, test-pulse and front-end reset strobes for an analogue readout chip, on a 40 MHz (25 ns) clock. A trigger comes either from an internal periodic generator or from an external line whose active polarity is selectable. Each accepted trigger starts two programmable delays: one ends in the trigger pulse sent to the chip, the other ends in a start-of-recording strobe for the data path.

One frequency input serves two purposes, chosen by the trigger-source bit. In internal mode it is the repetition period in clock cycles. In external mode it sets a deadtime of freq×64 cycles after each accepted trigger, during which further edges are ignored. The block also turns the burst setting into the number of time samples that each trigger reads out, (burst+1)×3, clamped at 30.

All settings are plain inputs held by a register file outside this block. Readout runs only while the run-enable input is high.

Top module: `fe_trig_seq`

## Requirements
- R1: `samples_o` equals (min(`burst_i`,9)+1)×3. It updates on the first rising edge after `burst_i` changes, so burst 9 and any larger value both give 30.
- R2: With `mode_i[2]`=0 (internal source) and `run_en_i`=1, a trigger is accepted every max(`freq_i`,1) rising edges. The first is accepted on the `freq_i`-th edge that samples `run_en_i` high.
- R3: With `mode_i[2]`=1 (external source), a trigger is accepted on the edge that first samples `ext_trig_i` XOR `mode_i[3]` as 1 after it was 0. `mode_i[3]`=1 means the line is active-low. The opposite transition of the line accepts nothing.
- R4: `trig_o` is high for exactly one cycle, starting at rising edge A+`trig_dly_i`+1, where A is the edge that accepted the trigger. A delay of 0 gives A+1.
- R5: `rec_o` is high for exactly one cycle, starting at rising edge A+`rec_dly_i`+1.
- R6: In external mode, edges sampled on the `freq_i`×64 edges after an acceptance are ignored, and the next edge may accept. `freq_i`=0 gives no deadtime.
- R7: No trigger is accepted while `run_en_i` is 0.
- R8: `tp_o` is high together with `trig_o` exactly when `mode_i[1]` was 1 on the accepting edge. Otherwise it stays low.
- R9: `fe_rst_o` pulses for one cycle after the first edge that samples `run_en_i` high following a low, provided `mode_i[0]`=1.
- R10: A trigger that arrives while either delay of an earlier trigger is still running is ignored.
- R11: During reset, `trig_o`, `rec_o`, `tp_o`, `fe_rst_o` and `samples_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 4 | [0] reset enable, [1] test pulse, [2] external source, [3] active-low input |
| burst_i | input | 4 | Burst setting n, giving (n+1)×3 samples |
| freq_i | input | 16 | Internal period, or external deadtime in units of 64 cycles |
| trig_dly_i | input | 16 | Cycles from acceptance to the trigger pulse |
| rec_dly_i | input | 16 | Cycles from acceptance to the recording strobe |
| run_en_i | input | 1 | Readout enable |
| ext_trig_i | input | 1 | External trigger line |
| trig_o | output | 1 | Trigger pulse to the chip |
| rec_o | output | 1 | Start-of-recording strobe |
| tp_o | output | 1 | Test-pulse flag, high with `trig_o` |
| fe_rst_o | output | 1 | Front-end reset pulse |
| samples_o | output | 5 | Samples read per trigger |

## Verification
An external edge driven just after edge c is accepted on edge c+1. Its trigger pulse is therefore due at edge c+`trig_dly_i`+2, and its recording strobe at edge c+`rec_dly_i`+2. In internal mode the first pulse falls at edge c+`freq_i`+`trig_dly_i`+1 after `run_en_i` is raised, and each later pulse follows `freq_i` edges on. `samples_o` and `fe_rst_o` follow their inputs after one edge. The bench counts rising edges, logs the edge after which each output pulse appears, and compares those logged edge numbers with the values above. It drives the deadtime window to both sides of its last ignored edge.

// File: rtl/fe_trig_pkg.sv
package fe_trig_pkg;
   // Field order matches the mode input: bit 3 down to bit 0
   typedef struct packed {
      logic inv_pol;   // bit 3: external line active-low
      logic ext_src;   // bit 2: external trigger source
      logic tp_en;     // bit 1: test pulse with each trigger
      logic rst_en;    // bit 0: front-end reset at run start
   } mode_t;

   localparam int unsigned SAMPLES_PER_STEP = 3;
endpackage

// File: rtl/fe_trig_edge.sv
module fe_trig_edge #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic invert_i,
   output logic rise_o
);
   logic line_s;
   logic level;
   logic level_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign line_s = raw_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= raw_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= sh[i-1];
            end
         end
      end
      assign line_s = sh[SYNC_STAGES-1];
   end

   assign level = line_s ^ invert_i;

   // Reset as "already active" so a level held at release is no edge
   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b1;
      else        level_q <= level;
   end

   assign rise_o = level & ~level_q;

   // R3
   single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/fe_delay_timer.sv
module fe_delay_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] len_i,
   output logic         busy_o,
   output logic         fire_o
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         busy_o <= 1'b0;
         fire_o <= 1'b0;
      end else begin
         fire_o <= 1'b0;
         if (start_i) begin
            cnt    <= len_i;
            busy_o <= 1'b1;
         end else if (busy_o) begin
            if (cnt == '0) begin
               busy_o <= 1'b0;
               fire_o <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R4
   fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !fire_o);
   // R10
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
endmodule

// File: rtl/fe_trig_source.sv
module fe_trig_source #(
   parameter int unsigned FREQ_W     = 16,
   parameter int unsigned DEAD_SHIFT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              ext_mode_i,
   input  logic [FREQ_W-1:0] freq_i,
   input  logic              ext_rise_i,
   input  logic              hold_i,
   output logic              accept_o
);
   localparam int unsigned DW = FREQ_W + DEAD_SHIFT;

   logic [FREQ_W-1:0] per_cnt;
   logic [FREQ_W-1:0] per_last;
   logic              tick;
   logic [DW-1:0]     dead_cnt;
   logic              ext_ok;

   assign per_last = (freq_i == '0) ? '0 : freq_i - 1'b1;
   assign tick     = run_i & ~ext_mode_i & (per_cnt >= per_last);
   assign ext_ok   = run_i & ext_mode_i & ext_rise_i & (dead_cnt == '0);
   assign accept_o = ~hold_i & (tick | ext_ok);

   always_ff @(posedge clk) begin
      if (!rst_n)                    per_cnt <= '0;
      else if (!run_i || ext_mode_i) per_cnt <= '0;
      else if (tick)                 per_cnt <= '0;
      else                           per_cnt <= per_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              dead_cnt <= '0;
      else if (!ext_mode_i)    dead_cnt <= '0;
      else if (accept_o)       dead_cnt <= {freq_i, {DEAD_SHIFT{1'b0}}};
      else if (dead_cnt != '0) dead_cnt <= dead_cnt - 1'b1;
   end

   // R6
   dead_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o && ext_mode_i && freq_i != '0) |=> (dead_cnt != '0));
   // R7
   run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> run_i);
endmodule

// File: rtl/fe_trig_seq.sv
module fe_trig_seq
   import fe_trig_pkg::*;
#(
   parameter int unsigned FREQ_W      = 16,
   parameter int unsigned DLY_W       = 16,
   parameter int unsigned BURST_W     = 4,
   parameter int unsigned SAMP_W      = 5,
   parameter int unsigned MAX_BURST   = 9,
   parameter int unsigned DEAD_SHIFT  = 6,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         mode_i,
   input  logic [BURST_W-1:0] burst_i,
   input  logic [FREQ_W-1:0]  freq_i,
   input  logic [DLY_W-1:0]   trig_dly_i,
   input  logic [DLY_W-1:0]   rec_dly_i,
   input  logic               run_en_i,
   input  logic               ext_trig_i,
   output logic               trig_o,
   output logic               rec_o,
   output logic               tp_o,
   output logic               fe_rst_o,
   output logic [SAMP_W-1:0]  samples_o
);
   localparam int unsigned NUM_TIMERS  = 2;
   localparam int unsigned MAX_SAMPLES = (MAX_BURST + 1) * SAMPLES_PER_STEP;

   if (MAX_BURST >= (1 << BURST_W)) begin : g_bad_burst
      $error("MAX_BURST does not fit BURST_W");
   end
   if (MAX_SAMPLES >= (1 << SAMP_W)) begin : g_bad_samp
      $error("sample count does not fit SAMP_W");
   end

   mode_t md;
   assign md = mode_t'(mode_i);

   // Sample count
   logic [BURST_W-1:0] b_clamp;
   logic [SAMP_W-1:0]  samp_d;
   assign b_clamp = (burst_i > BURST_W'(MAX_BURST)) ? BURST_W'(MAX_BURST) : burst_i;
   assign samp_d  = SAMP_W'(b_clamp) * SAMP_W'(SAMPLES_PER_STEP) + SAMP_W'(SAMPLES_PER_STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) samples_o <= '0;
      else        samples_o <= samp_d;
   end

   // Trigger sources
   logic ext_rise;
   logic accept;
   logic [NUM_TIMERS-1:0] tbusy;
   logic [NUM_TIMERS-1:0] tfire;

   fe_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_i    (ext_trig_i),
      .invert_i (md.inv_pol),
      .rise_o   (ext_rise)
   );

   fe_trig_source #(.FREQ_W(FREQ_W), .DEAD_SHIFT(DEAD_SHIFT)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_en_i),
      .ext_mode_i (md.ext_src),
      .freq_i     (freq_i),
      .ext_rise_i (ext_rise),
      .hold_i     (|tbusy),
      .accept_o   (accept)
   );

   // Delay timers: index 0 drives the trigger, index 1 the recording strobe
   logic [DLY_W-1:0] tlen [NUM_TIMERS];
   assign tlen[0] = trig_dly_i;
   assign tlen[1] = rec_dly_i;

   for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
      fe_delay_timer #(.W(DLY_W)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (accept),
         .len_i   (tlen[g]),
         .busy_o  (tbusy[g]),
         .fire_o  (tfire[g])
      );
   end

   assign trig_o = tfire[0];
   assign rec_o  = tfire[1];

   // Test-pulse flag captured at acceptance
   logic tp_armed;
   always_ff @(posedge clk) begin
      if (!rst_n)      tp_armed <= 1'b0;
      else if (accept) tp_armed <= md.tp_en;
   end
   assign tp_o = tfire[0] & tp_armed;

   // Front-end reset at run start
   logic run_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         fe_rst_o <= 1'b0;
      end else begin
         run_q    <= run_en_i;
         fe_rst_o <= run_en_i & ~run_q & md.rst_en;
      end
   end

   // R1
   samples_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      samples_o <= SAMP_W'(MAX_SAMPLES));
   // R8
   tp_with_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tp_o |-> trig_o);
   // R9
   rst_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fe_rst_o |-> $past(run_en_i));
   // R9
   rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fe_rst_o |=> !fe_rst_o);
endmodule

// File: tb/fe_trig_seq_tb.sv
module fe_trig_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  mode_i = '0;
   logic [3:0]  burst_i = '0;
   logic [15:0] freq_i = '0;
   logic [15:0] trig_dly_i = '0;
   logic [15:0] rec_dly_i = '0;
   logic        run_en_i = 1'b0;
   logic        ext_trig_i = 1'b0;
   logic        trig_o, rec_o, tp_o, fe_rst_o;
   logic [4:0]  samples_o;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int n_trig = 0, n_rec = 0, n_tp = 0, n_rst = 0;
   int trig_at [64];
   int rec_at  [64];
   int rst_at  [64];
   bit done = 1'b0;

   // {burst, expected samples}
   localparam logic [8:0] VEC [7] = '{
      {4'd0, 5'd3}, {4'd1, 5'd6}, {4'd4, 5'd15}, {4'd8, 5'd27},
      {4'd9, 5'd30}, {4'd10, 5'd30}, {4'd15, 5'd30}
   };

   always #5 clk = ~clk;

   fe_trig_seq u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .burst_i(burst_i),
      .freq_i(freq_i), .trig_dly_i(trig_dly_i), .rec_dly_i(rec_dly_i),
      .run_en_i(run_en_i), .ext_trig_i(ext_trig_i), .trig_o(trig_o),
      .rec_o(rec_o), .tp_o(tp_o), .fe_rst_o(fe_rst_o), .samples_o(samples_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (trig_o)   begin trig_at[n_trig % 64] = cyc; n_trig = n_trig + 1; end
      if (rec_o)    begin rec_at[n_rec % 64]   = cyc; n_rec  = n_rec + 1;  end
      if (tp_o)     n_tp = n_tp + 1;
      if (fe_rst_o) begin rst_at[n_rst % 64]   = cyc; n_rst  = n_rst + 1;  end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic pulse_ext(input logic active);
      ext_trig_i = active;
      wait_n(1);
      ext_trig_i = ~active;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int c, base, rbase, tbase;
      wait_n(3);
      // R11 reset state
      check(trig_o == 0,    "R11 trig_o",    trig_o,    0);
      check(rec_o == 0,     "R11 rec_o",     rec_o,     0);
      check(tp_o == 0,      "R11 tp_o",      tp_o,      0);
      check(fe_rst_o == 0,  "R11 fe_rst_o",  fe_rst_o,  0);
      check(samples_o == 0, "R11 samples_o", samples_o, 0);
      rst_n = 1'b1;
      wait_n(1);

      // R1 sample-count vectors
      for (int i = 0; i < 7; i++) begin
         burst_i = VEC[i][8:5];
         wait_n(2);
         check(samples_o == VEC[i][4:0], "R1 samples", samples_o, VEC[i][4:0]);
      end

      // R2 R4 R5 R8 internal source with test pulse
      trig_dly_i = 16'd3; rec_dly_i = 16'd5;
      mode_i = 4'b0010; freq_i = 16'd20;
      wait_n(2);
      base = n_trig; rbase = n_rec; tbase = n_tp;
      c = cyc; run_en_i = 1'b1;
      wait_until(c + 46);
      run_en_i = 1'b0;
      wait_n(2);
      check(n_trig - base == 2, "R2 internal count", n_trig - base, 2);
      check(trig_at[base] == c + 24, "R4 first trig edge", trig_at[base], c + 24);
      check(trig_at[base+1] == c + 44, "R2 period", trig_at[base+1], c + 44);
      check(rec_at[rbase] == c + 26, "R5 rec edge", rec_at[rbase], c + 26);
      check(n_tp - tbase == 2, "R8 tp count", n_tp - tbase, 2);
      wait_n(20);

      // R3 R6 external normal polarity with deadtime 128
      mode_i = 4'b0100; freq_i = 16'd2; ext_trig_i = 1'b0;
      wait_n(2); run_en_i = 1'b1; wait_n(2);
      base = n_trig; rbase = n_rec; tbase = n_tp;
      c = cyc; pulse_ext(1'b1);
      wait_until(c + 50);
      check(n_trig - base == 1, "R3 ext accepted", n_trig - base, 1);
      check(trig_at[base] == c + 5, "R4 ext trig edge", trig_at[base], c + 5);
      check(rec_at[rbase] == c + 7, "R5 ext rec edge", rec_at[rbase], c + 7);
      check(n_tp == tbase, "R8 no tp", n_tp - tbase, 0);
      pulse_ext(1'b1);
      wait_until(c + 127);
      pulse_ext(1'b1);
      wait_until(c + 129);
      check(n_trig - base == 1, "R6 inside deadtime", n_trig - base, 1);
      pulse_ext(1'b1);
      wait_until(c + 140);
      check(n_trig - base == 2, "R6 after deadtime", n_trig - base, 2);
      check(trig_at[base+1] == c + 134, "R6 first edge after", trig_at[base+1], c + 134);
      wait_n(150);

      // R7 run enable low
      run_en_i = 1'b0; wait_n(2);
      base = n_trig;
      pulse_ext(1'b1);
      wait_n(12);
      check(n_trig == base, "R7 run off", n_trig - base, 0);

      // R3 active-low input, R6 zero deadtime
      ext_trig_i = 1'b1; mode_i = 4'b1100; freq_i = 16'd0;
      wait_n(3); run_en_i = 1'b1; wait_n(2);
      base = n_trig;
      c = cyc; ext_trig_i = 1'b0;
      wait_n(2); ext_trig_i = 1'b1;
      wait_until(c + 10);
      check(n_trig - base == 1, "R3 inverted single", n_trig - base, 1);
      check(trig_at[base] == c + 5, "R3 inverted edge", trig_at[base], c + 5);
      pulse_ext(1'b0);
      wait_until(c + 20);
      check(n_trig - base == 2, "R6 zero deadtime", n_trig - base, 2);
      check(trig_at[base+1] == c + 15, "R6 zero deadtime edge", trig_at[base+1], c + 15);

      // R10 trigger while delay pending
      run_en_i = 1'b0; ext_trig_i = 1'b0; wait_n(1);
      mode_i = 4'b0100; trig_dly_i = 16'd20; rec_dly_i = 16'd2;
      wait_n(2); run_en_i = 1'b1; wait_n(2);
      base = n_trig;
      c = cyc; pulse_ext(1'b1);
      wait_until(c + 5); pulse_ext(1'b1);
      wait_until(c + 40);
      check(n_trig - base == 1, "R10 pending ignored", n_trig - base, 1);
      check(trig_at[base] == c + 22, "R10 long delay edge", trig_at[base], c + 22);

      // R4 zero delay
      trig_dly_i = 16'd0; wait_n(1);
      base = n_trig;
      c = cyc; pulse_ext(1'b1);
      wait_n(6);
      check(trig_at[base] == c + 2, "R4 zero delay", trig_at[base], c + 2);

      // R9 front-end reset at run start
      run_en_i = 1'b0; mode_i = 4'b0001; freq_i = 16'd1000;
      wait_n(3);
      check(n_rst == 0, "R9 no reset pulse without enable", n_rst, 0);
      c = cyc; run_en_i = 1'b1;
      wait_n(4);
      check(n_rst == 1, "R9 reset count", n_rst, 1);
      check(rst_at[0] == c + 1, "R9 reset edge", rst_at[0], c + 1);
      run_en_i = 1'b0;
      wait_n(2);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule